// File: doc/BRIEF.md
# Universal Shift and Storage Register with Shared Parallel Port

This block is a parameterised register, eight bits wide by default, with four operations: keep the stored word, move it one place toward the high end, move it one place toward the low end, or capture a whole word in parallel. A two-bit operation select chooses among them on each rising clock edge. An active-low clear, sampled on the clock, zeroes the word and takes precedence over every operation.

A single parallel port serves as both input and output. It is modelled as separate inbound and outbound buses plus a drive-enable. The register drives the port with its contents unless the parallel-capture operation is selected or either of two active-high port-disable inputs is high. During capture, the block releases the port so that an outside driver can supply the word.

Two serial outputs always show the lowest and highest stored bits. They ignore the port disables. Chaining one block's high tap into the next block's low-end serial input, and the second block's low tap back into the first block's high-end serial input, builds longer shift words.

Top module: `usr_shift_reg`

## Requirements
- R1: With `sel` = 2'b00 and `clr_n` high, a rising edge leaves all stored bits unchanged.
- R2: With `sel` = 2'b01 and `clr_n` high, a rising edge moves each bit i to bit i+1 and loads `ser_r` into bit 0. The old top bit is discarded.
- R3: With `sel` = 2'b10 and `clr_n` high, a rising edge moves each bit i to bit i-1 and loads `ser_l` into the top bit. The old bit 0 is discarded.
- R4: With `sel` = 2'b11 and `clr_n` high, a rising edge stores `pin_in`. While `sel` is 2'b11, `pin_oe` is low whatever the disable inputs are, so an outside driver on the port meets no contention.
- R5: When `clr_n` is low at a rising edge, the stored word and both taps become zero. A low `clr_n` between edges changes nothing.
- R6: A low `clr_n` takes priority over every `sel` value, including 2'b11.
- R7: When `oe_dis_a` or `oe_dis_b` is high, `pin_oe` is low. The disables have no effect on how the stored word is updated.
- R8: `pin_out` always carries the stored word. `pin_oe` is high exactly when `sel` is not 2'b11 and both disables are low.
- R9: `tap_lo` always equals stored bit 0 and `tap_hi` always equals the top stored bit, regardless of the disables.
- R10: Two blocks chained through the serial pins act as one register of twice the width, in both shift directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low |
| sel | input | 2 | Operation select: 00 keep, 01 toward high end, 10 toward low end, 11 parallel capture |
| oe_dis_a | input | 1 | Port disable, active high |
| oe_dis_b | input | 1 | Port disable, active high |
| ser_r | input | 1 | Serial bit entering bit 0 on a shift toward the high end |
| ser_l | input | 1 | Serial bit entering the top bit on a shift toward the low end |
| pin_in | input | WIDTH | Word seen on the shared port |
| pin_out | output | WIDTH | Word the block drives onto the shared port |
| pin_oe | output | 1 | Port drive-enable |
| tap_lo | output | 1 | Stored bit 0, always driven |
| tap_hi | output | 1 | Top stored bit, always driven |

## Verification
The clocked properties assume that `clr_n` is held low for at least one edge before any operation is checked. They also assume that `sel`, the serial inputs and `pin_in` are settled at each rising edge. The bench starts every run with a clear. It changes all inputs only on falling edges and samples results a quarter period after a rising edge, so every edge sees stable, known values. The sweep walks through all select, clear and disable combinations with varied serial bits and data, so the checks also hold when clear coincides with capture.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_KEEP  = 2'b00,
        MODE_RIGHT = 2'b01,
        MODE_LEFT  = 2'b10,
        MODE_LOAD  = 2'b11
    } mode_e;

    // Port may be driven only outside capture and with both disables low
    function automatic logic port_may_drive(mode_e m, logic dis_a, logic dis_b);
        return (m != MODE_LOAD) && !dis_a && !dis_b;
    endfunction

endpackage

// File: rtl/usr_next_state.sv
module usr_next_state
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    input  mode_e            mode,
    input  logic             clr_n,
    input  logic             ser_r,
    input  logic             ser_l,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] nxt
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] up_shift;
    logic [WIDTH-1:0] down_shift;

    // Bit 0 is the low end; shifting toward the high end enters at bit 0
    assign up_shift   = {cur[TOP-1:0], ser_r};
    assign down_shift = {ser_l, cur[TOP:1]};

    always_comb begin
        if (!clr_n) begin
            nxt = '0;
        end else begin
            unique case (mode)
                MODE_KEEP:  nxt = cur;
                MODE_RIGHT: nxt = up_shift;
                MODE_LEFT:  nxt = down_shift;
                MODE_LOAD:  nxt = par_in;
                default:    nxt = cur;
            endcase
        end
    end

endmodule

// File: rtl/usr_port_ctrl.sv
module usr_port_ctrl
    import usr_pkg::*;
(
    input  mode_e mode,
    input  logic  dis_a,
    input  logic  dis_b,
    output logic  drive
);

    assign drive = port_may_drive(mode, dis_a, dis_b);

    // R4: the port is released while capture is selected
    always_comb begin
        if (mode == MODE_LOAD) begin
            a_r4_release_on_load: assert (drive == 1'b0);
        end
    end

    // R7: either disable releases the port
    always_comb begin
        if (dis_a || dis_b) begin
            a_r7_disable_release: assert (drive == 1'b0);
        end
    end

endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       sel,
    input  logic             oe_dis_a,
    input  logic             oe_dis_b,
    input  logic             ser_r,
    input  logic             ser_l,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic             pin_oe,
    output logic             tap_lo,
    output logic             tap_hi
);

    localparam int TOP = WIDTH - 1;

    mode_e            mode;
    logic [WIDTH-1:0] store_q;
    logic [WIDTH-1:0] store_d;

    assign mode = mode_e'(sel);

    usr_next_state #(.WIDTH(WIDTH)) u_next (
        .cur    (store_q),
        .mode   (mode),
        .clr_n  (clr_n),
        .ser_r  (ser_r),
        .ser_l  (ser_l),
        .par_in (pin_in),
        .nxt    (store_d)
    );

    usr_port_ctrl u_port (
        .mode  (mode),
        .dis_a (oe_dis_a),
        .dis_b (oe_dis_b),
        .drive (pin_oe)
    );

    always_ff @(posedge clk) begin
        store_q <= store_d;
    end

    assign pin_out = store_q;
    assign tap_lo  = store_q[0];
    assign tap_hi  = store_q[TOP];

    // Checking starts after the first clear edge
    logic started = 1'b0;
    always_ff @(posedge clk) begin
        if (!clr_n) started <= 1'b1;
    end

    a_r1_keep: assert property (@(posedge clk) disable iff (!started)
        (clr_n && sel == 2'b00) |=> $stable(pin_out));

    a_r2_shift_up: assert property (@(posedge clk) disable iff (!started)
        (clr_n && sel == 2'b01) |=> (pin_out == {$past(pin_out[TOP-1:0]), $past(ser_r)}));

    a_r3_shift_down: assert property (@(posedge clk) disable iff (!started)
        (clr_n && sel == 2'b10) |=> (pin_out == {$past(ser_l), $past(pin_out[TOP:1])}));

    a_r4_capture: assert property (@(posedge clk) disable iff (!started)
        (clr_n && sel == 2'b11) |=> (pin_out == $past(pin_in)));

    // R5 and R6: clear wins over any select
    a_r5_clear: assert property (@(posedge clk)
        (!clr_n) |=> (pin_out == '0 && !tap_lo && !tap_hi));

endmodule

// File: tb/usr_shift_reg_test.sv
module usr_shift_reg_test;

    localparam int CLK_P = 10;
    localparam int W     = 8;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic [1:0]   sel = 2'b00;
    logic         dis_a = 1'b0, dis_b = 1'b0;
    logic         sr = 1'b0, sl = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic         oe, t_lo, t_hi;

    logic         casc = 1'b0;
    logic         sl_mux;
    logic [W-1:0] din2 = '0;
    logic [W-1:0] dout2;
    logic         oe2, t_lo2, t_hi2;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    assign sl_mux = casc ? t_lo2 : sl;

    usr_shift_reg #(.WIDTH(W)) uut (
        .clk(clk), .clr_n(clr_n), .sel(sel), .oe_dis_a(dis_a), .oe_dis_b(dis_b),
        .ser_r(sr), .ser_l(sl_mux), .pin_in(din), .pin_out(dout), .pin_oe(oe),
        .tap_lo(t_lo), .tap_hi(t_hi)
    );

    usr_shift_reg #(.WIDTH(W)) uut2 (
        .clk(clk), .clr_n(clr_n), .sel(sel), .oe_dis_a(1'b0), .oe_dis_b(1'b0),
        .ser_r(t_hi), .ser_l(sl), .pin_in(din2), .pin_out(dout2), .pin_oe(oe2),
        .tap_lo(t_lo2), .tap_hi(t_hi2)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [W-1:0] model = '0;

    // One operation: drive at falling edge, check drive-enable, clock, check state
    task automatic step(input logic c, input logic [1:0] s, input logic da, input logic db,
                        input logic r, input logic l, input logic [W-1:0] d, input string req);
        logic exp_oe;
        @(negedge clk);
        clr_n = c; sel = s; dis_a = da; dis_b = db; sr = r; sl = l; din = d;
        #1;
        exp_oe = (s != 2'b11) && !da && !db;
        check(da || db ? "R7 pin_oe" : (s == 2'b11 ? "R4 pin_oe" : "R8 pin_oe"), oe, exp_oe);
        if (!c)            model = '0;
        else if (s == 2'b01) model = {model[W-2:0], r};
        else if (s == 2'b10) model = {l, model[W-1:1]};
        else if (s == 2'b11) model = d;
        @(posedge clk);
        #(CLK_P/4);
        check(req, dout, model);
        check("R9 tap_lo", t_lo, model[0]);
        check("R9 tap_hi", t_hi, model[W-1]);
    endtask

    initial begin
        logic [W-1:0] lfsr;
        logic [2*W-1:0] word;
        @(posedge clk);
        #(CLK_P/4);
        check("R5 reset clear", dout, 0);
        check("R9 reset taps", {t_hi, t_lo}, 0);

        // All capture values, then keep with port enabled
        for (int v = 0; v < 256; v++) begin
            step(1, 2'b11, v[0], v[1], 0, 0, W'(v), "R4 capture");
            step(1, 2'b00, 0, 0, v[2], v[3], ~W'(v), "R1 keep");
        end

        // Clear against capture, and clear not acting between edges
        step(1, 2'b11, 0, 0, 0, 0, 8'hC3, "R4 capture");
        @(negedge clk);
        clr_n = 0; sel = 2'b00;
        #(CLK_P/4);
        check("R5 no async clear", dout, 8'hC3);
        step(0, 2'b11, 1, 0, 1, 1, 8'hFF, "R6 clear over capture");

        // Sweep of every control combination with varied data
        lfsr = 8'h5A;
        for (int i = 0; i < 1024; i++) begin
            logic [9:0] k;
            k = 10'(i);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(!(k[4:2] == 3'b111), k[1:0], k[5], k[6], k[7], k[8], lfsr,
                 k[4:2] == 3'b111 ? "R5 clear" :
                 k[1:0] == 2'b00 ? "R1 keep" :
                 k[1:0] == 2'b01 ? (k[5] | k[6] ? "R7 R2 up" : "R2 up") :
                 k[1:0] == 2'b10 ? (k[5] | k[6] ? "R7 R3 down" : "R3 down") : "R4 capture");
        end

        // R10: chained pair
        step(0, 2'b00, 0, 0, 0, 0, 0, "R5 clear");
        casc = 1;
        @(negedge clk);
        clr_n = 1; sel = 2'b11; din = 8'hA5; din2 = 8'h3C;
        @(posedge clk);
        word = {8'h3C, 8'hA5};
        for (int n = 0; n < 16; n++) begin
            @(negedge clk);
            sel = 2'b01; sr = n[0];
            word = {word[14:0], n[0]};
            @(posedge clk);
            #(CLK_P/4);
            if (n == 3 || n == 15) check("R10 chain up", {dout2, dout}, word);
        end
        for (int n = 0; n < 16; n++) begin
            @(negedge clk);
            sel = 2'b10; sl = n[1];
            word = {n[1], word[15:1]};
            @(posedge clk);
            #(CLK_P/4);
            if (n == 5 || n == 15) check("R10 chain down", {dout2, dout}, word);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule